// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block gathers up to 64 interrupt sources into one request line for a processor. Sources are arranged in banks of 32. Each bank offers four 32-bit registers, reached through a plain read/write port inside a 64-byte window. The event register holds latched edge interrupts. The enable register holds the per-source mask. The ack register clears latched events when software writes ones to it. The level register shows the live, synchronised state of every input.

A fixed per-bank level mask marks which sources are level-triggered. Level sources never latch. Software sees them only through the level register, so the pending set is (event | (level & level_mask)) & enable. An edge source latches only on a rising input while its enable bit is set. Setting an enable bit for an input that is already high therefore raises nothing. The OR of the pending sets of all banks drives the registered processor request. The same request also leaves on a cascade output, which can feed one input of another controller.

Top module: `ic_banked`

## Requirements
- R1: After reset, every enable and event bit reads 0, and `irq_out` and `cascade_out` are 0.
- R2: A 0-to-1 transition on an enabled edge source sets its event bit at the first clock edge that samples the input high. `irq_out` rises one clock edge after that.
- R3: A rising edge on a source whose enable bit is 0 does not set its event bit and does not raise `irq_out`.
- R4: Writing to ack (register offset 0x8) clears exactly the event bits written as 1 and leaves the others set. A read of ack returns 0.
- R5: If a rising edge and an ack clear hit the same event bit in the same cycle, the bit stays set.
- R6: Writing 1 to an enable bit while that edge source's input is already high sets no event bit and does not raise `irq_out`.
- R7: Sources in the level mask (bank 0 default 0x1ff00000, bits 20 to 28) never set event bits. The level register (offset 0xC) returns the synchronised raw input of all 32 sources. While a level source is enabled and high, `irq_out` is 1, and it falls two edges after the input falls.
- R8: A read of enable (offset 0x4) returns the last value written to it.
- R9: Bank 0 (sources 0 to 31) is decoded at base 0x20 and bank 1 (sources 32 to 63) at base 0x10. Within a bank the registers are event 0x0, enable 0x4, ack 0x8 and level 0xC. Any other address reads 0.
- R10: `irq_out` is the registered OR over all banks of (event | (level & level_mask)) & enable, and `cascade_out` equals `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_BANKS*32 | Interrupt source inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address within the 64-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after `rd_en` |
| irq_out | output | 1 | Registered interrupt request to the processor |
| cascade_out | output | 1 | Combined request for a primary controller input |

## Verification
Each source input passes through one register. An edge event is therefore visible to a read issued after the first edge that samples it, and `irq_out` follows one edge later: two edges after an input change for both edge and level sources. Register writes take effect at the edge that samples the strobe, and read data appears on `rdata` at the edge that samples `rd_en`. The bench drives every input on the falling edge and samples on the falling edge after the expected number of rising edges. For interrupt timing it checks both the edge before the change (still low) and the edge of the change, so a one-cycle shift in either direction is caught.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 6;

  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } ic_reg_e;

  // Bank 0 sits at 0x20, bank 1 at 0x10 (addr[5:4])
  function automatic logic [1:0] bank_code(input int b);
    return (b == 0) ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/ic_bank.sv
module ic_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] LVL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         wr_ena,
  input  logic         wr_ack,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] evt,
  output logic [W-1:0] ena,
  output logic [W-1:0] lvl,
  output logic         pend
);
  logic [W-1:0] src_q;
  logic [W-1:0] rise;
  logic [W-1:0] clr;

  assign rise = src & ~src_q & ena & ~LVL_MASK;
  assign clr  = wr_ack ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      evt   <= '0;
      ena   <= '0;
    end else begin
      src_q <= src;
      evt   <= (evt & ~clr) | rise;
      if (wr_ena) ena <= wdata;
    end
  end

  assign lvl  = src_q;
  assign pend = |((evt | (src_q & LVL_MASK)) & ena);
endmodule

// File: rtl/ic_readback.sv
module ic_readback
  import ic_pkg::*;
#(
  parameter int NB = 2,
  parameter int W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB*W-1:0]   evt_all,
  input  logic [NB*W-1:0]   ena_all,
  input  logic [NB*W-1:0]   lvl_all,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] mux;

  always_comb begin
    mux = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr[5:4] == bank_code(b) && addr[1:0] == 2'b00) begin
        case (ic_reg_e'(addr[3:2]))
          REG_EVENT:  mux = evt_all[b*W +: W];
          REG_ENABLE: mux = ena_all[b*W +: W];
          REG_LEVEL:  mux = lvl_all[b*W +: W];
          default:    mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= mux;
  end
endmodule

// File: rtl/ic_banked.sv
module ic_banked
  import ic_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter logic [31:0] LVL_MASK_B0 = 32'h1ff0_0000,
  parameter logic [31:0] LVL_MASK_B1 = 32'h0000_0000,
  localparam int NUM_SRC = NUM_BANKS * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rdata,
  output logic               irq_out,
  output logic               cascade_out
);
  logic [NUM_SRC-1:0]   evt_all;
  logic [NUM_SRC-1:0]   ena_all;
  logic [NUM_SRC-1:0]   lvl_all;
  logic [NUM_BANKS-1:0] pend;
  logic                 irq_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [WORD_W-1:0] MASK = (b == 0) ? LVL_MASK_B0 : LVL_MASK_B1;
    logic hit;
    assign hit = wr_en && addr[5:4] == bank_code(b) && addr[1:0] == 2'b00;

    ic_bank #(.W(WORD_W), .LVL_MASK(MASK)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .src    (src_in[b*WORD_W +: WORD_W]),
      .wr_ena (hit && ic_reg_e'(addr[3:2]) == REG_ENABLE),
      .wr_ack (hit && ic_reg_e'(addr[3:2]) == REG_ACK),
      .wdata  (wdata),
      .evt    (evt_all[b*WORD_W +: WORD_W]),
      .ena    (ena_all[b*WORD_W +: WORD_W]),
      .lvl    (lvl_all[b*WORD_W +: WORD_W]),
      .pend   (pend[b])
    );
  end

  ic_readback #(.NB(NUM_BANKS), .W(WORD_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .evt_all (evt_all),
    .ena_all (ena_all),
    .lvl_all (lvl_all),
    .rdata   (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend;
  end

  assign irq_out     = irq_q;
  assign cascade_out = irq_q;
endmodule

module ic_banked_chk #(
  parameter int NS = 64,
  parameter logic [NS-1:0] LVL_ALL = '0
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [5:0]    addr,
  input logic [31:0]   wdata,
  input logic [31:0]   rdata,
  input logic          irq_out,
  input logic [NS-1:0] evt_all,
  input logic [NS-1:0] ena_all
);
  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_out && evt_all == '0 && ena_all == '0));
  // R3
  p_no_latch_disabled_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_all & ~$past(evt_all) & ~$past(ena_all)) == '0);
  // R4
  p_ack_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[3:2] == 2'd2) |=> rdata == 32'h0);
  // R7
  p_level_no_event_r7: assert property (@(posedge clk) disable iff (rst)
    (evt_all & LVL_ALL) == '0);
  // R8
  p_enable_readback_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 6'h24) |=> ena_all[31:0] == $past(wdata));
endmodule

bind ic_banked ic_banked_chk #(
  .NS(NUM_SRC),
  .LVL_ALL((NUM_BANKS == 2) ? {LVL_MASK_B1, LVL_MASK_B0} : NUM_SRC'(LVL_MASK_B0))
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .irq_out (irq_out),
  .evt_all (evt_all),
  .ena_all (ena_all)
);

// File: tb/ic_banked_test.sv
module ic_banked_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out, cascade_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ic_banked uut (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out),
    .cascade_out(cascade_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    rd(6'h24, v); chk("R1 enable", v, 32'h0);
    rd(6'h20, v); chk("R1 event", v, 32'h0);
    rd(6'h14, v); chk("R1 enable bank1", v, 32'h0);
  endtask

  task automatic t_enable_rb;
    logic [31:0] v;
    wr(6'h24, 32'h1234_5678); rd(6'h24, v); chk("R8 readback", v, 32'h1234_5678);
    wr(6'h24, 32'h0); rd(6'h24, v); chk("R8 readback zero", v, 32'h0);
  endtask

  task automatic t_edge_ack;
    logic [31:0] v;
    wr(6'h24, 32'h0000_000C);
    @(negedge clk); src_in[3:2] = 2'b11;
    @(negedge clk); chk("R2 irq not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk); chk("R2 irq raised", {31'b0, irq_out}, 32'h1);
    rd(6'h20, v); chk("R2 event bits", v, 32'h0000_000C);
    wr(6'h28, 32'h0000_0004);
    rd(6'h20, v); chk("R4 selective clear", v, 32'h0000_0008);
    rd(6'h28, v); chk("R4 ack reads zero", v, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    @(negedge clk); src_in[3] = 1'b0;
    @(negedge clk); src_in[3] = 1'b1; wr_en = 1'b1; addr = 6'h28; wdata = 32'h8;
    @(negedge clk); wr_en = 1'b0;
    rd(6'h20, v); chk("R5 set beats clear", v, 32'h0000_0008);
    wr(6'h28, 32'h0000_000C);
    rd(6'h20, v); chk("R4 all cleared", v, 32'h0);
    wr(6'h24, 32'h0);
    src_in[3:2] = 2'b00;
    idle(2);
    chk("R4 irq low after clear", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_disabled_and_late_enable;
    logic [31:0] v;
    @(negedge clk); src_in[6] = 1'b1;
    idle(3);
    rd(6'h20, v); chk("R3 no latch when disabled", v, 32'h0);
    chk("R3 irq low", {31'b0, irq_out}, 32'h0);
    wr(6'h24, 32'h0000_0040);
    idle(3);
    rd(6'h20, v); chk("R6 enable on high input no event", v, 32'h0);
    chk("R6 irq low", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(6'h24, 32'h0010_0000);
    @(negedge clk); src_in[20] = 1'b1;
    @(negedge clk); chk("R7 irq not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk); chk("R7 level irq", {31'b0, irq_out}, 32'h1);
    rd(6'h20, v); chk("R7 no event for level", v, 32'h0);
    rd(6'h2C, v); chk("R7 level raw", v, 32'h0010_0040);
    @(negedge clk); src_in[20] = 1'b0;
    @(negedge clk); chk("R7 irq still high", {31'b0, irq_out}, 32'h1);
    @(negedge clk); chk("R7 irq follows level low", {31'b0, irq_out}, 32'h0);
    wr(6'h24, 32'h0);
  endtask

  task automatic t_bank1;
    logic [31:0] v;
    wr(6'h14, 32'h0000_0100);
    @(negedge clk); src_in[40] = 1'b1;
    idle(2);
    chk("R10 irq from bank1", {31'b0, irq_out}, 32'h1);
    chk("R10 cascade equals irq", {31'b0, cascade_out}, 32'h1);
    rd(6'h10, v); chk("R9 bank1 event", v, 32'h0000_0100);
    rd(6'h20, v); chk("R9 bank0 event untouched", v, 32'h0);
    rd(6'h1C, v); chk("R9 bank1 level", v, 32'h0000_0100);
    rd(6'h14, v); chk("R9 bank1 enable", v, 32'h0000_0100);
    rd(6'h00, v); chk("R9 unmapped reads zero", v, 32'h0);
    wr(6'h18, 32'h0000_0100);
    idle(2);
    chk("R10 irq low after bank1 ack", {31'b0, irq_out}, 32'h0);
    chk("R10 cascade low", {31'b0, cascade_out}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable_rb();
    t_edge_ack();
    t_set_wins();
    t_disabled_and_late_enable();
    t_level();
    t_bank1();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule